// File: doc/BRIEF.md
# Copy Burst Splitter with In-Flight Limit

This block turns one memory copy request into a stream of bus burst requests. A request carries a source address, a destination address and a byte count. The block walks the source range as read bursts and the destination range as write bursts. Each direction uses its own programmed burst size, and every burst is that full size except a shorter last one that covers the exact remainder. Read and write bursts are issued independently of each other on two valid/ready request channels.

Each direction also has a programmed cap on how many of its bursts may be in flight at once. A burst counts as in flight from its handshake until a one-cycle completion pulse arrives for that direction. When the cap is reached, that direction stops presenting bursts until a completion frees a slot. Once every burst of both directions has been issued and completed, the block raises a one-cycle done pulse and accepts the next request.

Two configuration words are written through a simple write port. Burst sizes must be a power of two from 128 to 1024 bytes. An illegal size field is refused and reported.

Top module: `burst_frag`

## Requirements
- R1: After reset no burst is presented, `done` and `cfg_err` are low, `req_ready` is high, both burst sizes are 1024 and both in-flight caps are 31.
- R2: A configuration write with `cfg_sel`=0 carries the write burst size in bits 31:16 and the read burst size in bits 15:0. A write with `cfg_sel`=1 carries the write cap in bits 20:16 and the read cap in bits 4:0.
- R3: A size field that is not a power of two, or lies outside 128..1024, leaves that direction's size unchanged. A legal field in the same write still takes effect. `cfg_err` is high for exactly the cycle after such a write and is low after every other write.
- R4: Read bursts start at the source address, write bursts start at the destination address, and each burst's address follows on from the end of the previous one in that direction. Every burst except the last is the programmed size.
- R5: The last burst of a direction carries the exact remaining length when that remainder is shorter than the burst size. A length that is an exact multiple of the size has no short burst, and no burst ever has length 0.
- R6: A direction never has more bursts in flight than its cap. When it is at the cap, its valid stays low until a completion for that direction arrives.
- R7: A programmed cap of 0 behaves as a cap of 1.
- R8: `done` is a single-cycle pulse that rises only after every burst of the request has been issued and completed. A zero-length request produces `done` without any burst.
- R9: `req_ready` is low from the cycle after a request is accepted until `done`. Burst sizes and caps written during a copy apply only from the next request.
- R10: A presented burst that is not accepted keeps its valid, address and length unchanged until its ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the size word, 1 the cap word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_err | output | 1 | Pulse: an illegal size field was refused |
| req_valid | input | 1 | Copy request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_src | input | AW | Copy source address |
| req_dst | input | AW | Copy destination address |
| req_len | input | LW | Copy length in bytes |
| rd_valid | output | 1 | Read burst presented |
| rd_ready | input | 1 | Read burst taken by the bus |
| rd_addr | output | AW | Read burst address |
| rd_len | output | BLW | Read burst length in bytes |
| rd_cpl | input | 1 | One read burst completed |
| wr_valid | output | 1 | Write burst presented |
| wr_ready | input | 1 | Write burst taken by the bus |
| wr_addr | output | AW | Write burst address |
| wr_len | output | BLW | Write burst length in bytes |
| wr_cpl | input | 1 | One write burst completed |
| done | output | 1 | Pulse: whole copy issued and completed |

## Verification
The assertions assume that the bus never pulses a completion for a direction that has nothing in flight. They also assume that a copy request is only offered while `req_ready` is high. The in-flight counter kept by the checker is only meaningful under that completion rule. The bench keeps its own count of granted bursts and only pulses a completion while that count is above zero. It drops `req_valid` in the cycle after acceptance. Backpressure is drawn from a pseudo-random ready pattern so that the hold rule is exercised without breaking these assumptions.

// File: rtl/burst_frag_pkg.sv
package burst_frag_pkg;

   localparam int unsigned SIZE_FIELD_W = 16;
   localparam int unsigned WR_FIELD_LSB = 16;

   // A burst size is legal when it is a power of two inside [lo, hi].
   function automatic logic size_legal(input logic [SIZE_FIELD_W-1:0] v,
                                       input int unsigned lo,
                                       input int unsigned hi);
      logic [31:0] w;
      w = {16'b0, v};
      return (w >= lo) && (w <= hi) && ((w & (w - 32'd1)) == 32'd0);
   endfunction

endpackage

// File: rtl/burst_frag_cfg.sv
module burst_frag_cfg #(
   parameter int MIN_BURST = 128,
   parameter int MAX_BURST = 1024,
   parameter int BLW       = 11,
   parameter int LIM_W     = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic             sel,
   input  logic [31:0]      wdata,
   output logic [BLW-1:0]   rd_size,
   output logic [BLW-1:0]   wr_size,
   output logic [LIM_W-1:0] rd_lim,
   output logic [LIM_W-1:0] wr_lim,
   output logic             err
);
   import burst_frag_pkg::*;

   localparam int FW = SIZE_FIELD_W;
   localparam int WL = WR_FIELD_LSB;

   if (BLW > FW) begin : g_bad_blw
      $error("burst size width exceeds the size field");
   end
   if (LIM_W > WL) begin : g_bad_lim
      $error("cap width exceeds its field");
   end

   logic [FW-1:0] f_rd, f_wr;
   logic          ok_rd, ok_wr;

   assign f_rd  = wdata[FW-1:0];
   assign f_wr  = wdata[WL +: FW];
   assign ok_rd = size_legal(f_rd, MIN_BURST, MAX_BURST);
   assign ok_wr = size_legal(f_wr, MIN_BURST, MAX_BURST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_size <= BLW'(MAX_BURST);
         wr_size <= BLW'(MAX_BURST);
         rd_lim  <= '1;
         wr_lim  <= '1;
         err     <= 1'b0;
      end else begin
         err <= 1'b0;
         if (we && !sel) begin
            if (ok_rd) rd_size <= f_rd[BLW-1:0];
            if (ok_wr) wr_size <= f_wr[BLW-1:0];
            err <= !(ok_rd && ok_wr);
         end else if (we) begin
            rd_lim <= wdata[LIM_W-1:0];
            wr_lim <= wdata[WL +: LIM_W];
         end
      end
   end

endmodule

// File: rtl/burst_frag_lane.sv
module burst_frag_lane #(
   parameter int AW        = 32,
   parameter int LW        = 20,
   parameter int BLW       = 11,
   parameter int CW        = 6,
   parameter int MAX_BURST = 1024
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [AW-1:0]  start_addr,
   input  logic [LW-1:0]  start_len,
   input  logic [BLW-1:0] size_in,
   input  logic [CW-1:0]  lim_in,
   input  logic           bus_ready,
   input  logic           cpl,
   output logic           bus_valid,
   output logic [AW-1:0]  bus_addr,
   output logic [BLW-1:0] bus_len,
   output logic           fin,
   output logic [CW-1:0]  lim_q
);
   logic [AW-1:0]  addr_q;
   logic [LW-1:0]  rem_q;
   logic [BLW-1:0] size_q;
   logic [CW-1:0]  outs_q, outs_n;
   logic           fire, drop;
   logic [BLW-1:0] cur_len;

   // Full-size burst while more than one size remains, else the tail.
   assign cur_len   = (rem_q > LW'(size_q)) ? size_q : rem_q[BLW-1:0];
   assign bus_valid = (rem_q != '0) && (outs_q < lim_q);
   assign bus_addr  = addr_q;
   assign bus_len   = cur_len;
   assign fire      = bus_valid && bus_ready;
   assign drop      = cpl && (outs_q != '0);
   assign fin       = (rem_q == '0) && (outs_q == '0);

   always_comb begin
      outs_n = outs_q;
      if (fire) outs_n = outs_n + CW'(1);
      if (drop) outs_n = outs_n - CW'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         rem_q  <= '0;
         size_q <= BLW'(MAX_BURST);
         lim_q  <= CW'(1);
         outs_q <= '0;
      end else begin
         outs_q <= outs_n;
         if (start) begin
            addr_q <= start_addr;
            rem_q  <= start_len;
            size_q <= size_in;
            lim_q  <= lim_in;
         end else if (fire) begin
            addr_q <= addr_q + AW'(cur_len);
            rem_q  <= rem_q - LW'(cur_len);
         end
      end
   end

endmodule

// File: rtl/burst_frag.sv
module burst_frag #(
   parameter int AW        = 32,
   parameter int LW        = 20,
   parameter int LIM_W     = 5,
   parameter int MIN_BURST = 128,
   parameter int MAX_BURST = 1024,
   localparam int BLW      = $clog2(MAX_BURST) + 1,
   localparam int CW       = LIM_W + 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cfg_we,
   input  logic           cfg_sel,
   input  logic [31:0]    cfg_wdata,
   output logic           cfg_err,
   input  logic           req_valid,
   output logic           req_ready,
   input  logic [AW-1:0]  req_src,
   input  logic [AW-1:0]  req_dst,
   input  logic [LW-1:0]  req_len,
   output logic           rd_valid,
   input  logic           rd_ready,
   output logic [AW-1:0]  rd_addr,
   output logic [BLW-1:0] rd_len,
   input  logic           rd_cpl,
   output logic           wr_valid,
   input  logic           wr_ready,
   output logic [AW-1:0]  wr_addr,
   output logic [BLW-1:0] wr_len,
   input  logic           wr_cpl,
   output logic           done
);
   localparam int NLANE = 2;  // lane 0 reads the source, lane 1 writes the destination

   if ((MIN_BURST & (MIN_BURST - 1)) != 0 || (MAX_BURST & (MAX_BURST - 1)) != 0) begin : g_bad_pow2
      $error("burst size limits must be powers of two");
   end
   if (MIN_BURST > MAX_BURST || MIN_BURST < 1) begin : g_bad_range
      $error("burst size range is empty");
   end
   if (LW < BLW) begin : g_bad_len
      $error("length width narrower than a burst length");
   end
   if (MAX_BURST > 32768) begin : g_bad_max
      $error("burst size does not fit its configuration field");
   end

   logic [BLW-1:0]   rd_size_q, wr_size_q;
   logic [LIM_W-1:0] rd_lim_q, wr_lim_q;

   burst_frag_cfg #(
      .MIN_BURST(MIN_BURST), .MAX_BURST(MAX_BURST), .BLW(BLW), .LIM_W(LIM_W)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
      .rd_size(rd_size_q), .wr_size(wr_size_q),
      .rd_lim(rd_lim_q), .wr_lim(wr_lim_q), .err(cfg_err)
   );

   logic                     busy_q, accept, fin_all;
   logic [NLANE-1:0]         lane_valid, lane_fin, lane_rdy, lane_cpl;
   logic [NLANE-1:0][AW-1:0] lane_addr;
   logic [NLANE-1:0][BLW-1:0] lane_len;
   logic [NLANE-1:0][CW-1:0] lane_lim;

   assign accept    = req_valid && !busy_q;
   assign req_ready = !busy_q;
   assign lane_rdy  = {wr_ready, rd_ready};
   assign lane_cpl  = {wr_cpl, rd_cpl};
   assign fin_all   = &lane_fin;

   for (genvar gi = 0; gi < NLANE; gi++) begin : g_lane
      logic [LIM_W-1:0] raw_lim;
      logic [CW-1:0]    eff_lim;
      logic [BLW-1:0]   raw_size;
      logic [AW-1:0]    base;

      assign raw_lim  = (gi == 0) ? rd_lim_q  : wr_lim_q;
      assign raw_size = (gi == 0) ? rd_size_q : wr_size_q;
      assign base     = (gi == 0) ? req_src   : req_dst;
      // A cap of zero would never issue; it is served as one slot.
      assign eff_lim  = (raw_lim == '0) ? CW'(1) : CW'(raw_lim);

      burst_frag_lane #(
         .AW(AW), .LW(LW), .BLW(BLW), .CW(CW), .MAX_BURST(MAX_BURST)
      ) u_lane (
         .clk(clk), .rst_n(rst_n), .start(accept),
         .start_addr(base), .start_len(req_len),
         .size_in(raw_size), .lim_in(eff_lim),
         .bus_ready(lane_rdy[gi]), .cpl(lane_cpl[gi]),
         .bus_valid(lane_valid[gi]), .bus_addr(lane_addr[gi]),
         .bus_len(lane_len[gi]), .fin(lane_fin[gi]), .lim_q(lane_lim[gi])
      );
   end

   assign rd_valid = lane_valid[0];
   assign rd_addr  = lane_addr[0];
   assign rd_len   = lane_len[0];
   assign wr_valid = lane_valid[1];
   assign wr_addr  = lane_addr[1];
   assign wr_len   = lane_len[1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= busy_q && fin_all;
         if (accept)
            busy_q <= 1'b1;
         else if (busy_q && fin_all)
            busy_q <= 1'b0;
      end
   end

endmodule

// File: rtl/burst_frag_chk.sv
module burst_frag_chk #(
   parameter int AW        = 32,
   parameter int BLW       = 11,
   parameter int CW        = 6,
   parameter int MAX_BURST = 1024
) (
   input logic           clk,
   input logic           rst_n,
   input logic           cfg_we,
   input logic           cfg_sel,
   input logic           cfg_err,
   input logic           req_valid,
   input logic           req_ready,
   input logic           rd_valid,
   input logic           rd_ready,
   input logic [AW-1:0]  rd_addr,
   input logic [BLW-1:0] rd_len,
   input logic           rd_cpl,
   input logic           wr_valid,
   input logic           wr_ready,
   input logic [AW-1:0]  wr_addr,
   input logic [BLW-1:0] wr_len,
   input logic           wr_cpl,
   input logic           done,
   input logic [CW-1:0]  rd_lim,
   input logic [CW-1:0]  wr_lim
);
   logic [CW-1:0] rd_cnt, wr_cnt;

   // In-flight counts rebuilt from the port handshakes and completions.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_cnt <= '0;
         wr_cnt <= '0;
      end else begin
         rd_cnt <= rd_cnt + CW'(rd_valid && rd_ready) - CW'(rd_cpl && rd_cnt != '0);
         wr_cnt <= wr_cnt + CW'(wr_valid && wr_ready) - CW'(wr_cpl && wr_cnt != '0);
      end
   end

   // R10
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr) && $stable(rd_len));
   // R10
   wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_len));
   // R6
   rd_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> rd_cnt < rd_lim);
   // R6
   wr_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> wr_cnt < wr_lim);
   // R5
   rd_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> rd_len != '0 && rd_len <= BLW'(MAX_BURST));
   // R5
   wr_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> wr_len != '0 && wr_len <= BLW'(MAX_BURST));
   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R8
   done_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> rd_cnt == '0 && wr_cnt == '0);
   // R9
   busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready);
   // R3
   err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> $past(cfg_we) && !$past(cfg_sel));

endmodule

bind burst_frag burst_frag_chk #(
   .AW(AW), .BLW(BLW), .CW(CW), .MAX_BURST(MAX_BURST)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_err(cfg_err),
   .req_valid(req_valid), .req_ready(req_ready),
   .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_len(rd_len), .rd_cpl(rd_cpl),
   .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_len(wr_len), .wr_cpl(wr_cpl),
   .done(done), .rd_lim(lane_lim[0]), .wr_lim(lane_lim[1])
);

// File: tb/burst_frag_test.sv
module burst_frag_test;
   localparam int AW = 32, LW = 20, BLW = 11;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_we = 1'b0, cfg_sel = 1'b0, cfg_err;
   logic [31:0] cfg_wdata = '0;
   logic req_valid = 1'b0, req_ready;
   logic [AW-1:0] req_src = '0, req_dst = '0;
   logic [LW-1:0] req_len = '0;
   logic rd_valid, rd_ready = 1'b1, rd_cpl = 1'b0;
   logic wr_valid, wr_ready = 1'b1, wr_cpl = 1'b0;
   logic [AW-1:0] rd_addr, wr_addr;
   logic [BLW-1:0] rd_len, wr_len;
   logic done;

   burst_frag uut (.*);

   always #10 clk = ~clk;  // 50 MHz

   int checks = 0, failures = 0;
   int exp_rsz = 1024, exp_wsz = 1024, exp_rlim = 31, exp_wlim = 31;
   int rd_out = 0, wr_out = 0, rd_n = 0, wr_n = 0, done_cnt = 0, done_base = 0;
   bit auto_cpl = 1'b1, rand_ready = 1'b0, ended = 1'b0;
   logic [15:0] lf = 16'hACE1;
   logic [AW-1:0] rq_a[$], wq_a[$];
   int rq_l[$], wq_l[$];

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   // Monitor and bus responder: decide ready/completion for the next edge,
   // then score any burst granted at that edge.
   initial forever begin
      bit rf, wf, rc, wc;
      @(negedge clk);
      if (done) done_cnt++;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      rd_ready = rand_ready ? lf[0] : 1'b1;
      wr_ready = rand_ready ? lf[3] : 1'b1;
      rc = auto_cpl && rd_out > 0 && lf[5];
      wc = auto_cpl && wr_out > 0 && lf[7];
      rd_cpl = rc;
      wr_cpl = wc;
      rf = rd_valid && rd_ready;
      wf = wr_valid && wr_ready;
      if (rf) begin
         check(rd_out < exp_rlim, "R6 read in-flight below cap", rd_out, exp_rlim);
         if (rq_a.size() == 0) check(1'b0, "R4 unexpected read burst", rd_addr, 0);
         else begin
            logic [AW-1:0] ea;
            int el;
            ea = rq_a.pop_front();
            el = rq_l.pop_front();
            check(rd_addr == ea, "R4 read burst address", rd_addr, ea);
            check(int'(rd_len) == el, "R5 read burst length", rd_len, el);
         end
         rd_n++;
      end
      if (wf) begin
         check(wr_out < exp_wlim, "R6 write in-flight below cap", wr_out, exp_wlim);
         if (wq_a.size() == 0) check(1'b0, "R4 unexpected write burst", wr_addr, 0);
         else begin
            logic [AW-1:0] ea;
            int el;
            ea = wq_a.pop_front();
            el = wq_l.pop_front();
            check(wr_addr == ea, "R4 write burst address", wr_addr, ea);
            check(int'(wr_len) == el, "R5 write burst length", wr_len, el);
         end
         wr_n++;
      end
      rd_out = rd_out + int'(rf) - int'(rc);
      wr_out = wr_out + int'(wf) - int'(wc);
   end

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   task automatic cfg_write(input bit sel, input logic [31:0] data, input bit exp_err, input string tag);
      @(posedge clk); #2;
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
      @(posedge clk); #2;
      cfg_we = 1'b0;
      @(negedge clk);
      check(cfg_err == exp_err, tag, cfg_err, exp_err);
   endtask

   // Driver: push the expected bursts, then hand the request over.
   task automatic start_copy(input logic [AW-1:0] s, input logic [AW-1:0] d, input int len);
      int r, b;
      logic [AW-1:0] a;
      r = len; a = s;
      while (r > 0) begin
         b = (r > exp_rsz) ? exp_rsz : r;
         rq_a.push_back(a); rq_l.push_back(b); a += AW'(b); r -= b;
      end
      r = len; a = d;
      while (r > 0) begin
         b = (r > exp_wsz) ? exp_wsz : r;
         wq_a.push_back(a); wq_l.push_back(b); a += AW'(b); r -= b;
      end
      rd_n = 0; wr_n = 0; done_base = done_cnt;
      @(posedge clk); #2;
      req_valid = 1'b1; req_src = s; req_dst = d; req_len = LW'(len);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      @(posedge clk); #2;
      req_valid = 1'b0;
   endtask

   task automatic wait_done(input string tag);
      while (done_cnt == done_base) @(negedge clk);
      check(rq_a.size() == 0 && wq_a.size() == 0, {tag, " all bursts issued"}, rq_a.size() + wq_a.size(), 0);
      check(rd_out == 0 && wr_out == 0, {tag, " all bursts completed"}, rd_out + wr_out, 0);
      @(negedge clk);
      check(done == 1'b0, {tag, " done lasts one cycle"}, done, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(!rd_valid && !wr_valid, "R1 no burst after reset", {rd_valid, wr_valid}, 0);
      check(!done && !cfg_err, "R1 done/err low after reset", {done, cfg_err}, 0);
      check(req_ready, "R1 ready after reset", req_ready, 1);

      // R1 default sizes 1024 and caps 31 seen through a copy
      start_copy(32'h0000_0100, 32'h0000_4000, 2100);
      wait_done("R1 default sizes");

      // R2 size word: write size in 31:16, read size in 15:0
      cfg_write(1'b0, {16'd128, 16'd256}, 1'b0, "R2 legal size write no error");
      exp_rsz = 256; exp_wsz = 128;
      // R2 cap word: write cap in 20:16, read cap in 4:0
      cfg_write(1'b1, {11'd0, 5'd3, 11'd0, 5'd2}, 1'b0, "R2 cap write no error");
      exp_rlim = 2; exp_wlim = 3;

      rand_ready = 1'b1;
      start_copy(32'h0001_0000, 32'h0002_0010, 1000);
      wait_done("R4 copy with tail");
      check(rd_n == 4 && wr_n == 8, "R5 burst counts for 1000 bytes", rd_n * 100 + wr_n, 408);

      start_copy(32'h0003_0000, 32'h0004_0000, 512);
      wait_done("R5 exact multiple");
      check(rd_n == 2, "R5 no short read burst on exact multiple", rd_n, 2);

      start_copy(32'h0005_0004, 32'h0006_0008, 100);
      wait_done("R5 single short burst");
      check(rd_n == 1 && wr_n == 1, "R5 one burst per direction", rd_n + wr_n, 2);

      start_copy(32'h0007_0000, 32'h0008_0000, 0);
      wait_done("R8 zero length");
      check(rd_n == 0 && wr_n == 0, "R8 zero length issues no burst", rd_n + wr_n, 0);

      // R3 both fields illegal: nothing changes
      cfg_write(1'b0, {16'd2048, 16'd384}, 1'b1, "R3 illegal sizes flagged");
      @(negedge clk);
      check(cfg_err == 1'b0, "R3 error is one cycle", cfg_err, 0);
      // R3 write field illegal, read field legal
      cfg_write(1'b0, {16'd64, 16'd512}, 1'b1, "R3 partly illegal write flagged");
      exp_rsz = 512;
      start_copy(32'h0009_0000, 32'h000A_0000, 600);
      wait_done("R3 kept and updated sizes");

      // R6 caps hold bursts until completions arrive
      auto_cpl = 1'b0; rand_ready = 1'b0;
      start_copy(32'h0010_0000, 32'h0020_0000, 4096);
      repeat (30) @(negedge clk);
      check(rd_n == 2, "R6 read bursts stop at cap", rd_n, 2);
      check(wr_n == 3, "R6 write bursts stop at cap", wr_n, 3);
      check(!rd_valid && !wr_valid, "R6 valid low at cap", {rd_valid, wr_valid}, 0);
      check(done_cnt == done_base, "R8 no done while bursts pending", done_cnt - done_base, 0);
      auto_cpl = 1'b1;
      wait_done("R6 resume after completions");

      // R7 cap of zero acts as one
      cfg_write(1'b1, 32'd0, 1'b0, "R7 zero cap write no error");
      exp_rlim = 1; exp_wlim = 1;
      auto_cpl = 1'b0;
      start_copy(32'h0030_0000, 32'h0040_0000, 1024);
      repeat (20) @(negedge clk);
      check(rd_n == 1 && wr_n == 1, "R7 zero cap allows one in flight", rd_n + wr_n, 2);
      auto_cpl = 1'b1;
      wait_done("R7 zero cap copy");

      // R9 busy while copying; sizes written mid-copy wait for the next request
      rand_ready = 1'b1;
      start_copy(32'h0050_0000, 32'h0060_0000, 3000);
      @(negedge clk);
      check(req_ready == 1'b0, "R9 not ready while busy", req_ready, 0);
      cfg_write(1'b0, {16'd256, 16'd256}, 1'b0, "R9 mid-copy size write");
      wait_done("R9 copy keeps old sizes");
      exp_rsz = 256; exp_wsz = 256;
      start_copy(32'h0070_0000, 32'h0080_0000, 600);
      wait_done("R9 new sizes on next copy");
      check(rd_n == 3 && wr_n == 3, "R9 new sizes applied", rd_n + wr_n, 6);

      // R10 hold under backpressure is watched on every cycle by the checker
      check(req_ready == 1'b1, "R10 idle after final copy", req_ready, 1);
      repeat (5) @(posedge clk);
      finish_run();
   end

endmodule